// File: doc/BRIEF.md
# Sector Page Load Program Controller

This block is a clocked model of the write path of a byte-wide memory that is reprogrammed one 256-byte sector at a time. A host presents bytes with a single-cycle write strobe. The first accepted strobe opens a load window and fixes the target sector. The bytes go into a page latch in any order. The window stays open while strobes keep arriving within a set number of idle cycles. Once that many cycles pass with no accepted strobe, the block enters a timed program phase. At the end of that phase the whole sector is rewritten in one step. Every byte that was not loaded during the window reads back as FFh.

During the program phase the busy output is high and byte strobes are dropped. A read at any address then returns status instead of array data. The status byte holds the inverted bit 7 of the last loaded byte, a bit 6 that alternates on each read, and the last loaded byte's own bits 5:0. A host can therefore detect completion by polling either bit. When busy falls, reads return true array contents again.

The array, the page latch and the timers are all internal. Both the idle window and the program time are parameters counted in clock cycles.

Top module: `sector_prog_ctrl`

## Requirements
- R1: The address is split so that bits 7:0 give the byte within a sector and the upper bits give the sector. A read strobe returns the addressed array byte on rdData with rdValid high in the cycle after the strobe.
- R2: Bytes of one window may be loaded in any address order, and each loaded byte lands at its own byte index.
- R3: The program phase begins WIN_CYC cycles after the last accepted strobe of a window. busy rises exactly WIN_CYC clock edges after that strobe's edge, and every accepted strobe restarts this count.
- R4: At the end of the program phase, every byte of the target sector that was not loaded in the window reads FFh, including bytes that held data before. Other sectors are unchanged.
- R5: busy stays high for exactly PROG_CYC cycles. The array takes its new contents on the same edge at which busy falls.
- R6: A byte strobe that arrives while busy is high is ignored and leaves the array unchanged.
- R7: A read during the program phase returns a status byte. Its bit 7 is the complement of bit 7 of the last loaded byte, and its bits 5:0 equal bits 5:0 of that byte.
- R8: Status bit 6 is 0 on the first read of a program phase and alternates on every later read in the same phase.
- R9: During a load window, a strobe whose sector differs from the window's sector is ignored. It neither loads data nor restarts the idle count.
- R10: If one byte index is strobed more than once in a window, the last data written is programmed.
- R11: After reset, busy and rdValid are low and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Byte write strobe, one cycle per byte |
| wrAddr | input | ADDR_W | Write address: sector in the upper bits, byte index in bits 7:0 |
| wrData | input | 8 | Write data byte |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Read result, array byte or status byte |
| rdValid | output | 1 | High in the cycle after a read strobe |
| busy | output | 1 | High during the program phase |

## Verification
The bench builds the block with ADDR_W=10, which gives four sectors, with WIN_CYC=6 and PROG_CYC=24. At these values a full window and program phase take a few dozen cycles. The exact busy rise and fall edges can then be measured against the last accepted strobe. Several status reads, and a dropped strobe, still fit inside one program phase. With four sectors the bench can also show that programming one sector leaves its neighbours intact, and that a strobe into a foreign sector does not extend the window.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // byte index inside a sector; the sector size is 2**IDX_W bytes
  localparam int IDX_W = 8;
  localparam int PAGE_BYTES = 1 << IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } spcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;      // write wrData into the page latch
    logic clearMask;  // first byte of a new window: forget earlier loads
    logic commit;     // last program cycle: rewrite the sector
    logic status;     // this read returns status, not array data
    logic toggle;     // current value of the alternating status bit
  } spcCtl_t;

endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WIN_CYC  = 7500,
  parameter int PROG_CYC = 500000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic                    rdEn,
  output spcCtl_t                 ctl,
  output logic [ADDR_W-IDX_W-1:0] curSector,
  output logic [IDX_W-1:0]        lastIdx,
  output logic                    busy
);

  localparam int SEC_W = ADDR_W - IDX_W;
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);

  spcState_t  state;
  logic [WIN_W-1:0] idleCnt;
  logic [PRG_W-1:0] progCnt;
  logic             toggleQ;
  logic             sameSec;
  logic             accept;
  logic             winDone;
  logic             progDone;

  always_comb begin
    sameSec  = (wrAddr[ADDR_W-1:IDX_W] == curSector);
    accept   = wrEn && ((state == ST_IDLE) || ((state == ST_LOAD) && sameSec));
    winDone  = (idleCnt == WIN_W'(WIN_CYC - 1));
    progDone = (progCnt == PRG_W'(PROG_CYC - 1));
    ctl.latch     = accept;
    ctl.clearMask = wrEn && (state == ST_IDLE);
    ctl.commit    = (state == ST_PROG) && progDone;
    ctl.status    = rdEn && (state == ST_PROG);
    ctl.toggle    = toggleQ;
  end

  assign busy = (state == ST_PROG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idleCnt   <= '0;
      progCnt   <= '0;
      toggleQ   <= 1'b0;
      curSector <= '0;
      lastIdx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_LOAD;
            curSector <= wrAddr[ADDR_W-1:IDX_W];
            lastIdx   <= wrAddr[IDX_W-1:0];
            idleCnt   <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            lastIdx <= wrAddr[IDX_W-1:0];
            idleCnt <= '0;
          end else if (winDone) begin
            state   <= ST_PROG;
            progCnt <= '0;
            toggleQ <= 1'b0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (ctl.status) toggleQ <= ~toggleQ;
          if (progDone) state <= ST_IDLE;
          else          progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SECTOR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(curSector)) // R9
    else $error("sector changed inside a load window");

  AST_PROG_ONLY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(state) == ST_LOAD)) // R3
    else $error("program phase entered without a load window");

  AST_PROG_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (progCnt < PRG_W'(PROG_CYC))) // R5
    else $error("program counter overran");

  AST_TOGGLE_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !toggleQ) // R8
    else $error("status toggle not cleared at program entry");

  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.status && !progDone) |=> (toggleQ != $past(toggleQ))) // R8
    else $error("status toggle did not alternate");

  logic [SEC_W-1:0] unusedSec;
  assign unusedSec = curSector;

endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  spcCtl_t                 ctl,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [7:0]              wrData,
  input  logic [ADDR_W-IDX_W-1:0] curSector,
  input  logic [IDX_W-1:0]        lastIdx,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [7:0]              rdData,
  output logic                    rdValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]            pageData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loadMask;
  logic [7:0]            memArr   [DEPTH];
  logic [7:0]            lastByte;

  assign lastByte = pageData[lastIdx];

  // page latch: data needs no reset, the mask says which entries are live
  always_ff @(posedge clk) begin
    if (ctl.latch) pageData[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadMask <= '0;
    end else begin
      if (ctl.clearMask) loadMask <= '0;
      if (ctl.latch)     loadMask[wrIdx] <= 1'b1;
    end
  end

  // backing array: erase-then-program of the whole sector on commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= 8'hFF;
    end else if (ctl.commit) begin
      for (int b = 0; b < PAGE_BYTES; b++) begin
        memArr[{curSector, IDX_W'(b)}] <= loadMask[b] ? pageData[b] : 8'hFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= 8'h00;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (ctl.status)
        rdData <= {~lastByte[7], ctl.toggle, lastByte[5:0]};
      else if (rdEn)
        rdData <= memArr[rdAddr];
    end
  end

  AST_NO_LATCH_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.latch && ctl.commit)) // R6
    else $error("byte latched during program phase");

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn)) // R1
    else $error("rdValid without a preceding read strobe");

  AST_STATUS_FROM_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.status |-> loadMask[lastIdx]) // R7
    else $error("status byte taken from an unloaded entry");

endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WIN_CYC  = 7500,
  parameter int PROG_CYC = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busy
);

  localparam int SEC_W = ADDR_W - IDX_W;

  spcCtl_t          ctl;
  logic [SEC_W-1:0] curSector;
  logic [IDX_W-1:0] lastIdx;

  spc_ctrl #(
    .ADDR_W  (ADDR_W),
    .WIN_CYC (WIN_CYC),
    .PROG_CYC(PROG_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .rdEn     (rdEn),
    .ctl      (ctl),
    .curSector(curSector),
    .lastIdx  (lastIdx),
    .busy     (busy)
  );

  spc_datapath #(
    .ADDR_W(ADDR_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrIdx    (wrAddr[IDX_W-1:0]),
    .wrData   (wrData),
    .curSector(curSector),
    .lastIdx  (lastIdx),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: tb/sim_sector_prog_ctrl.sv
module sim_sector_prog_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int WIN_CYC    = 6;
  localparam int PROG_CYC   = 24;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0]        wrData = '0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [7:0]        rdData;
  logic              rdValid;
  logic              busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int riseCyc = -1;
  int fallCyc = -1;
  int strobeCyc = 0;
  bit busyPrev = 1'b0;
  bit done = 1'b0;

  sector_prog_ctrl #(
    .ADDR_W(ADDR_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // busy edge monitor, sampled well after the clock edge
  always @(posedge clk) begin
    #2;
    if (busy && !busyPrev) riseCyc = cyc;
    if (!busy && busyPrev) fallCyc = cyc;
    busyPrev = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    strobeCyc = cyc;
  endtask

  task automatic rdByte(input logic [ADDR_W-1:0] a, output logic [7:0] d, output logic v);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; v = rdValid;
  endtask

  task automatic expectRd(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    logic v;
    rdByte(a, d, v);
    chk(v && d == exp, req, {v, d}, {1'b1, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitBusy();
    int n = 0;
    while (!busy && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic waitDone(input int mark);
    int n = 0;
    while (!(fallCyc > riseCyc && riseCyc > mark) && n < 2000) begin @(negedge clk); n++; end
    chk(riseCyc > mark && fallCyc - riseCyc == PROG_CYC, "R5 busy length",
        fallCyc - riseCyc, PROG_CYC);
  endtask

  task automatic t_reset();
    chk(!busy && !rdValid, "R11 reset outputs", {busy, rdValid}, 0);
    expectRd(10'h000, 8'hFF, "R11 erased array low");
    expectRd(10'h3FF, 8'hFF, "R11 erased array high");
    idle(1);
    chk(!rdValid, "R1 rdValid one cycle", rdValid, 0);
  endtask

  task automatic t_basic();
    int first;
    logic [7:0] d;
    logic v;
    wrByte(10'h005, 8'h3C);
    first = strobeCyc;
    wrByte(10'h002, 8'h81);
    wrByte(10'h005, 8'hA7);               // R10 rewrite of the same index
    idle(WIN_CYC - 2);
    chk(!busy, "R3 no program inside window", busy, 0);
    wrByte(10'h0F0, 8'h5E);               // restarts the idle count
    waitBusy();
    chk(riseCyc - strobeCyc == WIN_CYC, "R3 window timeout", riseCyc - strobeCyc, WIN_CYC);
    rdByte(10'h0F0, d, v);
    chk(v && d == 8'h9E, "R7 R8 first status read", d, 8'h9E);
    rdByte(10'h123, d, v);
    chk(v && d == 8'hDE, "R8 second status read", d, 8'hDE);
    rdByte(10'h0F0, d, v);
    chk(v && d == 8'h9E, "R8 third status read", d, 8'h9E);
    wrByte(10'h003, 8'h11);               // R6 dropped
    waitDone(first);
    expectRd(10'h005, 8'hA7, "R10 last write wins");
    expectRd(10'h002, 8'h81, "R2 out of order byte");
    expectRd(10'h0F0, 8'h5E, "R2 high index byte");
    expectRd(10'h003, 8'hFF, "R6 strobe during program ignored");
    expectRd(10'h0FF, 8'hFF, "R4 unloaded byte erased");
  endtask

  task automatic t_otherSector();
    int first;
    logic [7:0] d;
    logic v;
    wrByte(10'h140, 8'hC3);
    first = strobeCyc;
    waitBusy();
    rdByte(10'h140, d, v);
    chk(v && d == 8'h03, "R7 status bit7 inverted to 0", d, 8'h03);
    rdByte(10'h140, d, v);
    chk(v && d == 8'h43, "R8 status toggles", d, 8'h43);
    waitDone(first);
    expectRd(10'h140, 8'hC3, "R1 sector 1 byte");
    expectRd(10'h005, 8'hA7, "R4 other sector untouched");
  endtask

  task automatic t_reprogram();
    int first;
    wrByte(10'h002, 8'h00);
    first = strobeCyc;
    waitDone(first);
    expectRd(10'h002, 8'h00, "R4 reloaded byte");
    expectRd(10'h005, 8'hFF, "R4 previously programmed byte erased");
    expectRd(10'h140, 8'hC3, "R4 neighbour sector kept");
  endtask

  task automatic t_foreign();
    int first;
    wrByte(10'h200, 8'h12);
    first = strobeCyc;
    idle(WIN_CYC - 2);
    wrByte(10'h310, 8'h34);               // R9 other sector: dropped
    waitBusy();
    chk(riseCyc - first == WIN_CYC, "R9 foreign strobe does not restart window",
        riseCyc - first, WIN_CYC);
    waitDone(first);
    expectRd(10'h200, 8'h12, "R9 own sector loaded");
    expectRd(10'h310, 8'hFF, "R9 foreign byte not written");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_otherSector();
    t_reprogram();
    t_foreign();
    idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule